// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregator with End-of-Interrupt Re-Arm

This block gathers the interrupt lines of a USB OTG controller into two register banks and one level interrupt output. The endpoint bank collects 16 transmit lines and 15 receive lines. The core bank collects 9 controller event lines. Each bank keeps a raw source word, write-one-to-set and write-one-to-clear aliases for that word, a mask word with its own set and clear aliases, and a masked view equal to source AND mask.

The interrupt output is high while any masked bit is pending and the block is armed. When the output falls because software acknowledges the pending bits, the block stays disarmed. New events are recorded but do not raise the output until software writes the end-of-interrupt register. The block also has a constant identification word, a status word carrying the VBUS-drive line, and a self-clearing soft-reset bit.

Top module: `dual_bank_irq_agg`

## Requirements
- R1: After the synchronous active-low reset, every source and mask word reads 0 and `irq_o` is low.
- R2: Byte offset 0x00 always reads the nonzero constant 0x4E1A0102. Offset 0x08 reads `vbus_drive_i` in bit 0 and zeros above it. Unmapped offsets, 0x10 and 0x5C among them, read 0.
- R3: A write to a set alias (endpoint 0x24, core 0x44) ORs the data into the source. A write to a clear alias (0x28, 0x48) clears the source bits that are 1 in the data. The mask words at 0x2C and 0x4C take the written value directly, and their aliases (set 0x30/0x50, clear 0x34/0x54) act in the same way as the source aliases. Writes to 0x00, 0x08, the source words 0x20 and 0x40, and the masked words 0x38 and 0x58 change nothing.
- R4: In the endpoint bank, transmit endpoint k sits at bit k (0..15) and receive endpoint k (1..15) sits at bit 16+k. Bit 16 is always 0 in the source and in the mask.
- R5: In the core bank, event line j sits at bit 16+j (j = 0..8), and every other bit is always 0. Setting bit 24, the VBUS-drive event, through the set alias raises `irq_o` in the same way as the hardware line does.
- R6: The masked words at 0x38 and 0x58 read the AND of their bank's source and mask.
- R7: `irq_o` is high in the cycle after an edge that leaves a masked bit pending while the block is armed, and it is low whenever nothing is pending.
- R8: When `irq_o` falls because the pending bits are cleared, it stays low even if new bits become pending. A write of any value to 0x60 re-arms the block, and the output then rises if a bit is pending. Reset arms the block.
- R9: A hardware event that arrives in the same cycle as a clear-alias write covering its bit is kept in the source.
- R10: Writing 1 to bit 0 of the control word at 0x04 clears all source and mask bits at that edge, including events of that same cycle. Control bit 0 then reads 1 for exactly one cycle and 0 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| vbus_drive_i | input | 1 | VBUS-drive level shown in the status word |
| ep_tx_evt_i | input | 16 | Transmit endpoint event lines, endpoint k on bit k |
| ep_rx_evt_i | input | 15 | Receive endpoint event lines, endpoint k+1 on bit k |
| core_evt_i | input | 9 | Controller core event lines |
| irq_o | output | 1 | Level interrupt output |

## Verification
Two pairs of operations can land on the same clock edge. In the first pair, the bench drives a transmit endpoint event in the cycle in which software writes the acknowledgement to the clear alias for that bit. The source must still hold the bit afterwards. In the second pair, the bench writes the soft reset while event lines are active, and every word must read zero afterwards. A behavioural reference model updates on every edge and is compared with `irq_o` on every cycle, so a wrong order between arming and acknowledgement is caught in the exact cycle it occurs.

// File: rtl/irqg_pkg.sv
// Shared constants and types for the dual-bank interrupt aggregator.
// Assumes a 32-bit register bus with byte offsets on an 8-bit address.
package irqg_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 8;

    localparam logic [AW-1:0] OFS_REV      = 8'h00;
    localparam logic [AW-1:0] OFS_CTRL     = 8'h04;
    localparam logic [AW-1:0] OFS_STAT     = 8'h08;
    localparam logic [AW-1:0] OFS_EP_SRC   = 8'h20;
    localparam logic [AW-1:0] OFS_EP_SET   = 8'h24;
    localparam logic [AW-1:0] OFS_EP_CLR   = 8'h28;
    localparam logic [AW-1:0] OFS_EP_MSK   = 8'h2C;
    localparam logic [AW-1:0] OFS_EP_MSET  = 8'h30;
    localparam logic [AW-1:0] OFS_EP_MCLR  = 8'h34;
    localparam logic [AW-1:0] OFS_EP_MSKD  = 8'h38;
    localparam logic [AW-1:0] OFS_CO_SRC   = 8'h40;
    localparam logic [AW-1:0] OFS_CO_SET   = 8'h44;
    localparam logic [AW-1:0] OFS_CO_CLR   = 8'h48;
    localparam logic [AW-1:0] OFS_CO_MSK   = 8'h4C;
    localparam logic [AW-1:0] OFS_CO_MSET  = 8'h50;
    localparam logic [AW-1:0] OFS_CO_MCLR  = 8'h54;
    localparam logic [AW-1:0] OFS_CO_MSKD  = 8'h58;
    localparam logic [AW-1:0] OFS_EOI      = 8'h60;

    // Per-bank write strobes produced by the address decoder.
    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_wr;
        logic msk_set;
        logic msk_clr;
    } bank_wr_t;
endpackage

// File: rtl/irqg_decode.sv
// Address decoder: turns a bus write into one-hot strobes for the two banks,
// the control word and the end-of-interrupt register.
// Assumes one access per cycle. Read-only and unmapped offsets give no strobe.
module irqg_decode
    import irqg_pkg::*;
(
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output bank_wr_t      ep_w,
    output bank_wr_t      co_w,
    output logic          ctrl_wr,
    output logic          eoi_wr
);
    // Build the strobes from a write and the byte offset.
    always_comb begin
        ep_w    = '0;
        co_w    = '0;
        ctrl_wr = 1'b0;
        eoi_wr  = 1'b0;
        if (wr) begin
            case (addr)
                OFS_EP_SET:  ep_w.src_set = 1'b1;
                OFS_EP_CLR:  ep_w.src_clr = 1'b1;
                OFS_EP_MSK:  ep_w.msk_wr  = 1'b1;
                OFS_EP_MSET: ep_w.msk_set = 1'b1;
                OFS_EP_MCLR: ep_w.msk_clr = 1'b1;
                OFS_CO_SET:  co_w.src_set = 1'b1;
                OFS_CO_CLR:  co_w.src_clr = 1'b1;
                OFS_CO_MSK:  co_w.msk_wr  = 1'b1;
                OFS_CO_MSET: co_w.msk_set = 1'b1;
                OFS_CO_MCLR: co_w.msk_clr = 1'b1;
                OFS_CTRL:    ctrl_wr      = 1'b1;
                OFS_EOI:     eoi_wr       = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irqg_bank.sv
// One interrupt bank: source and mask words, each with set and clear aliases.
// Bits outside VALID are never stored. A hardware event in the same cycle as a
// clear write wins. A soft clear wipes both words and drops that cycle's events.
// Also gives the current and the next-cycle pending flag.
module irqg_bank
    import irqg_pkg::*;
#(
    parameter logic [DW-1:0] VALID = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  bank_wr_t      w,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] msk_q,
    output logic          pend,
    output logic          pend_n
);
    logic [DW-1:0] src_n;
    logic [DW-1:0] msk_n;

    // Next source and mask. Software writes first, then hardware events on top.
    always_comb begin
        src_n = src_q;
        msk_n = msk_q;
        if (soft_clr) begin
            src_n = '0;
            msk_n = '0;
        end else begin
            if (w.src_set) src_n = src_n | wdata;
            if (w.src_clr) src_n = src_n & ~wdata;
            src_n = (src_n | evt) & VALID;
            if (w.msk_wr)  msk_n = wdata;
            if (w.msk_set) msk_n = msk_n | wdata;
            if (w.msk_clr) msk_n = msk_n & ~wdata;
            msk_n = msk_n & VALID;
        end
    end

    // Register the bank words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            msk_q <= '0;
        end else begin
            src_q <= src_n;
            msk_q <= msk_n;
        end
    end

    assign pend   = |(src_q & msk_q);
    assign pend_n = |(src_n & msk_n);

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (w.src_set && !soft_clr) |=> ((src_q & $past(wdata) & VALID) == ($past(wdata) & VALID))); // R3
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (w.src_clr && !soft_clr) |=> ((src_q & $past(wdata) & ~$past(evt)) == '0)); // R3
    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr) |=> ((src_q & $past(evt) & VALID) == ($past(evt) & VALID))); // R9
    AST_SOFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (src_q == '0 && msk_q == '0)); // R10
endmodule

// File: rtl/irqg_eoi_gate.sv
// Re-arm gate: passes the pending level to the output while armed. When the
// output falls because pending clears, the gate disarms, and only a write to
// the end-of-interrupt register re-arms it. Reset leaves the gate armed.
module irqg_eoi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic eoi_wr,
    input  logic pend,
    input  logic pend_n,
    output logic irq_o
);
    logic spent_q;

    assign irq_o = pend & ~spent_q;

    // Disarm once the output has fired and pending falls; the EOI write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       spent_q <= 1'b0;
        else if (eoi_wr)  spent_q <= 1'b0;
        else if (irq_o && !pend_n) spent_q <= 1'b1;
    end

    AST_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (spent_q && !eoi_wr) |=> !irq_o); // R8
    AST_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> !irq_o); // R7
endmodule

// File: rtl/dual_bank_irq_agg.sv
// Top of the interrupt aggregator. Maps the endpoint and core lines into their
// bank words, decodes the register bus, drives the combinational read mux, keeps
// the self-clearing soft-reset bit and the re-arm gate.
// Assumes TX_EP <= 16, RX_EP <= 15 and CORE_LSB + CORE_EV <= 32.
module dual_bank_irq_agg
    import irqg_pkg::*;
#(
    parameter int unsigned   TX_EP    = 16,
    parameter int unsigned   RX_EP    = 15,
    parameter int unsigned   CORE_EV  = 9,
    parameter int unsigned   CORE_LSB = 16,
    parameter logic [DW-1:0] REV_ID   = 32'h4E1A_0102
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic               vbus_drive_i,
    input  logic [TX_EP-1:0]   ep_tx_evt_i,
    input  logic [RX_EP-1:0]   ep_rx_evt_i,
    input  logic [CORE_EV-1:0] core_evt_i,
    output logic               irq_o
);
    localparam int unsigned   RX_LSB     = 17;
    localparam logic [DW-1:0] EP_VALID   = DW'((64'd1 << TX_EP) - 64'd1)
                                         | (DW'((64'd1 << RX_EP) - 64'd1) << RX_LSB);
    localparam logic [DW-1:0] CORE_VALID = DW'((64'd1 << CORE_EV) - 64'd1) << CORE_LSB;

    bank_wr_t      ep_w, co_w;
    logic          ctrl_wr, eoi_wr, soft_clr;
    logic          srst_q;
    logic [DW-1:0] ep_evt, co_evt;
    logic [DW-1:0] ep_src, ep_msk, co_src, co_msk;
    logic          ep_pend, ep_pend_n, co_pend, co_pend_n;

    irqg_decode u_dec (
        .wr(bus_wr), .addr(bus_addr),
        .ep_w(ep_w), .co_w(co_w), .ctrl_wr(ctrl_wr), .eoi_wr(eoi_wr)
    );

    assign soft_clr = ctrl_wr & bus_wdata[0];
    assign ep_evt   = DW'(ep_tx_evt_i) | (DW'(ep_rx_evt_i) << RX_LSB);
    assign co_evt   = DW'(core_evt_i) << CORE_LSB;

    irqg_bank #(.VALID(EP_VALID)) u_ep (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .w(ep_w), .wdata(bus_wdata),
        .evt(ep_evt), .src_q(ep_src), .msk_q(ep_msk), .pend(ep_pend), .pend_n(ep_pend_n)
    );

    irqg_bank #(.VALID(CORE_VALID)) u_core (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .w(co_w), .wdata(bus_wdata),
        .evt(co_evt), .src_q(co_src), .msk_q(co_msk), .pend(co_pend), .pend_n(co_pend_n)
    );

    irqg_eoi_gate u_gate (
        .clk(clk), .rst_n(rst_n), .eoi_wr(eoi_wr),
        .pend(ep_pend | co_pend), .pend_n(ep_pend_n | co_pend_n), .irq_o(irq_o)
    );

    // Soft-reset bit: set by the write, reads back for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= soft_clr;
    end

    // Read mux; unmapped offsets read zero.
    always_comb begin
        case (bus_addr)
            OFS_REV:     bus_rdata = REV_ID;
            OFS_CTRL:    bus_rdata = DW'(srst_q);
            OFS_STAT:    bus_rdata = DW'(vbus_drive_i);
            OFS_EP_SRC:  bus_rdata = ep_src;
            OFS_EP_MSK:  bus_rdata = ep_msk;
            OFS_EP_MSKD: bus_rdata = ep_src & ep_msk;
            OFS_CO_SRC:  bus_rdata = co_src;
            OFS_CO_MSK:  bus_rdata = co_msk;
            OFS_CO_MSKD: bus_rdata = co_src & co_msk;
            default:     bus_rdata = '0;
        endcase
    end

    AST_REV_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_REV) |-> (bus_rdata == REV_ID && REV_ID != '0)); // R2
    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && !soft_clr) |=> !srst_q); // R10
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (((ep_src & ep_msk) | (co_src & co_msk)) != '0)); // R7
endmodule

// File: tb/dual_bank_irq_agg_tb.sv
module dual_bank_irq_agg_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EP_OK = 32'hFFFE_FFFF;
    localparam logic [31:0] CO_OK = 32'h01FF_0000;
    localparam logic [31:0] REV   = 32'h4E1A_0102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vbus_drive_i = 1'b1;
    logic [15:0] ep_tx_evt_i = '0;
    logic [14:0] ep_rx_evt_i = '0;
    logic [8:0]  core_evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_eps, m_epm, m_cos, m_com;
    bit m_spent;

    dual_bank_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vbus_drive_i(vbus_drive_i),
        .ep_tx_evt_i(ep_tx_evt_i), .ep_rx_evt_i(ep_rx_evt_i),
        .core_evt_i(core_evt_i), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_pend();
        return ((m_eps & m_epm) | (m_cos & m_com)) != 0;
    endfunction

    // Behavioural model updated on every rising edge
    always @(posedge clk) begin
        bit irq_now;
        logic [31:0] ev_ep, ev_co;
        if (!rst_n) begin
            m_eps = 0; m_epm = 0; m_cos = 0; m_com = 0; m_spent = 0;
        end else begin
            irq_now = m_pend() && !m_spent;
            ev_ep = {ep_rx_evt_i, 1'b0, ep_tx_evt_i};
            ev_co = {7'd0, core_evt_i, 16'd0};
            if (bus_wr && bus_addr == 8'h04 && bus_wdata[0]) begin
                m_eps = 0; m_epm = 0; m_cos = 0; m_com = 0;
            end else begin
                if (bus_wr) begin
                    case (bus_addr)
                        8'h24: m_eps = m_eps | bus_wdata;
                        8'h28: m_eps = m_eps & ~bus_wdata;
                        8'h2C: m_epm = bus_wdata;
                        8'h30: m_epm = m_epm | bus_wdata;
                        8'h34: m_epm = m_epm & ~bus_wdata;
                        8'h44: m_cos = m_cos | bus_wdata;
                        8'h48: m_cos = m_cos & ~bus_wdata;
                        8'h4C: m_com = bus_wdata;
                        8'h50: m_com = m_com | bus_wdata;
                        8'h54: m_com = m_com & ~bus_wdata;
                        default: ;
                    endcase
                end
                m_eps = (m_eps | ev_ep) & EP_OK;
                m_epm = m_epm & EP_OK;
                m_cos = (m_cos | ev_co) & CO_OK;
                m_com = m_com & CO_OK;
            end
            if (bus_wr && bus_addr == 8'h60) m_spent = 0;
            else if (irq_now && !m_pend()) m_spent = 1;
        end
    end

    // Compare the output with the model on every cycle (R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_o !== (m_pend() && !m_spent)) begin
                errors++;
                $display("FAIL R7/R8 per-cycle irq_o: actual=%0b expected=%0b at %0t",
                         irq_o, m_pend() && !m_spent, $time);
            end
        end
    end

    task automatic wr_ev(input logic [7:0] a, input logic [31:0] d, input bit do_wr,
                         input logic [15:0] tx, input logic [14:0] rx, input logic [8:0] co);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = do_wr;
        ep_tx_evt_i = tx; ep_rx_evt_i = rx; core_evt_i = co;
        @(negedge clk);
        bus_wr = 1'b0; ep_tx_evt_i = '0; ep_rx_evt_i = '0; core_evt_i = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_ev(a, d, 1'b1, '0, '0, '0);
    endtask

    task automatic rd_now(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%02h: actual=0x%08h expected=0x%08h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_now(a, exp, tag);
    endtask

    task automatic irq_is(input bit exp, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq_o: actual=%0b expected=%0b", tag, irq_o, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(8'h20, 32'h0, "R1");
        rd(8'h40, 32'h0, "R1");
        rd(8'h2C, 32'h0, "R1");
        irq_is(1'b0, "R1");
        // R2: identification, status, unmapped offsets
        rd(8'h00, REV, "R2");
        rd(8'h08, 32'h1, "R2");
        rd(8'h10, 32'h0, "R2");
        rd(8'h5C, 32'h0, "R2");
        // R4: endpoint layout, bit 16 absent
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h20, 32'hFFFE_FFFF, "R4");
        irq_is(1'b0, "R6");
        // R3: clear alias
        wr(8'h28, 32'h0000_FFFF);
        rd(8'h20, 32'hFFFE_0000, "R3");
        // R4/R6: mask write, masked view
        wr(8'h2C, 32'h0003_0000);
        rd(8'h2C, 32'h0002_0000, "R4");
        rd(8'h38, 32'h0002_0000, "R6");
        irq_is(1'b1, "R7");
        // R3: writes to read-only words ignored
        wr(8'h20, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h38, 32'h0);
        rd(8'h20, 32'hFFFE_0000, "R3");
        rd(8'h00, REV, "R3");
        // R8: acknowledge, then new event held off until EOI
        wr(8'h28, 32'hFFFF_FFFF);
        irq_is(1'b0, "R8");
        wr_ev(8'h00, 32'h0, 1'b0, '0, 15'h0001, '0);
        rd(8'h20, 32'h0002_0000, "R4");
        irq_is(1'b0, "R8");
        wr(8'h60, 32'h0000_1234);
        irq_is(1'b1, "R8");
        // R9: event and clear write in the same cycle
        wr(8'h30, 32'h0000_0008);
        wr_ev(8'h28, 32'h0002_0008, 1'b1, 16'h0008, '0, '0);
        rd(8'h20, 32'h0000_0008, "R9");
        rd(8'h38, 32'h0000_0008, "R9");
        irq_is(1'b1, "R9");
        // R5: core bank and software-set VBUS-drive event
        wr(8'h34, 32'hFFFF_FFFF);
        irq_is(1'b0, "R8");
        wr(8'h60, 32'h0);
        wr(8'h50, 32'h0100_0000);
        irq_is(1'b0, "R5");
        wr(8'h44, 32'h0100_0000);
        irq_is(1'b1, "R5");
        rd(8'h58, 32'h0100_0000, "R5");
        wr_ev(8'h00, 32'h0, 1'b0, '0, '0, 9'h001);
        rd(8'h40, 32'h0101_0000, "R5");
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h40, 32'h01FF_0000, "R5");
        // R10: soft reset with events in the same cycle
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h1; bus_wr = 1'b1;
        ep_tx_evt_i = 16'h0001; core_evt_i = 9'h001;
        @(negedge clk);
        bus_wr = 1'b0; ep_tx_evt_i = '0; core_evt_i = '0;
        rd_now(8'h04, 32'h1, "R10");
        rd(8'h04, 32'h0, "R10");
        rd(8'h20, 32'h0, "R10");
        rd(8'h40, 32'h0, "R10");
        rd(8'h2C, 32'h0, "R10");
        rd(8'h4C, 32'h0, "R10");
        irq_is(1'b0, "R10");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule